// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port with Ready Indicator

This block is the digital serial port of one sampling converter that can be strung with identical devices on a shared three-wire bus: a conversion strobe `cnv`, a serial clock `sck` and a serial data line. Each device drives `sdo` into the `sdi` of the next device toward the host. The device farthest from the host has its `sdi` tied to `cnv`. All pins are sampled on the system clock `clk`, and edges on `cnv` and `sck` are found by comparing each sample with the one before it.

A rising `cnv` while `sck` is high starts a conversion and selects chained operation with the ready indicator. A behavioural conversion timer hands in the 16-bit result over a valid/ready interface. `res_ready` is high only while the port is converting and `cnv` is still high. A producer may raise `res_valid` early and hold it with its data. The word is taken in the first cycle in which both are high, and `res_ready` drops afterwards. Once its word is held, a device passes its `sdi` level to `sdo`. The host therefore sees `sdo` rise only when every device in the chain has its result.

The first falling `sck` edge after that consumes the ready slot and shows the local MSB. Each later falling edge shows the next lower bit. At the same time each later falling edge shifts the upstream `sdo` into the register. Upstream words therefore follow the local word with no gap. Dropping `cnv` ends the cycle at any point.

Top module: `dchain_port`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `sdo` is 0 and `res_ready` is 0.
- R2: A rising `cnv` sampled while `sck` is 1 moves an idle port into conversion. From the next cycle, `res_ready` is 1 for as long as `cnv` stays 1 and no word has been taken.
- R3: A rising `cnv` sampled while `sck` is 0 is ignored. The port stays idle, `res_ready` stays 0 and `sdo` stays 0.
- R4: A word is taken in the cycle where `res_valid` and `res_ready` are both 1. `res_ready` is 0 from the next cycle on. A `res_valid` raised while the port is idle is held off and is taken in the first cycle of conversion.
- R5: During conversion `sdo` is 0. Once the local word is held and before the first falling `sck`, `sdo` equals `sdi`. So at the host end of the chain `sdo` rises only when all devices hold their words.
- R6: After the first falling `sck` following the ready slot, `sdo` shows bit 15 of the local word. After falling edge k (k = 1..16), `sdo` shows bit 16-k.
- R7: From the second falling edge on, each falling edge shifts `sdi` into the register. After falling edge 16+j, `sdo` shows the upstream `sdo` as it was after falling edge j. In a three-device chain the host sees the near word, then the middle word, then the far word, 48 bits in all, and then ones taken from `cnv`.
- R8: `cnv` sampled at 0 returns the port to idle from any state. After that, `sdo` is 0. This takes priority over a handshake or a falling `sck` in the same cycle, and a result offered in that cycle is not taken.
- R9: Falling `sck` edges during conversion have no effect. The ready indication and the word read back afterwards are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Conversion strobe; held high through conversion and readback |
| sck | input | 1 | Serial clock; falling edges shift data |
| sdi | input | 1 | Serial input from the upstream device (tied to `cnv` on the far device) |
| sdo | output | 1 | Serial output toward the host: ready level, then data |
| res_valid | input | 1 | Conversion result offered |
| res_ready | output | 1 | Port can take a result (converting, `cnv` high) |
| res_data | input | 16 | Conversion result, MSB is bit 15 |

## Verification
Two pairs of events can fall in the same cycle. The first pair is `cnv` dropping and a result handshake. The second pair is `cnv` dropping and a falling `sck` during readback. The bench provokes the first pair by lowering `cnv` in the same cycle that it raises `res_valid` on the near device. It then restarts a conversion and checks that `res_ready` is high again and that the near word read back is the new word, not the offered one. For the second pair it lowers `sck` and `cnv` together in the middle of a readback and requires `sdo` to be 0 in the following sample.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_ARMED = 2'd2,
    ST_SHIFT = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc_pin_sampler.sv
// Keeps the previous sample of each strobe pin so that edges can be found.
module dc_pin_sampler #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] prev
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) prev[g] <= 1'b0;
      else        prev[g] <= pin[g];
    end
  end
endmodule

// File: rtl/dc_ctrl.sv
// Mode selection, conversion, ready slot and readback sequencing.
module dc_ctrl
  import dc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnv,
  input  logic      cnv_prev,
  input  logic      sck,
  input  logic      sck_prev,
  input  logic      res_valid,
  output logic      res_ready,
  output logic      load,
  output logic      shift,
  output dc_state_e state
);
  logic      cnv_rise;
  logic      sck_fall;
  dc_state_e state_d;

  assign cnv_rise  = cnv & ~cnv_prev;
  assign sck_fall  = sck_prev & ~sck;
  assign res_ready = (state == ST_CONV) & cnv;
  assign load      = res_valid & res_ready;
  assign shift     = (state == ST_SHIFT) & cnv & sck_fall;

  always_comb begin
    state_d = state;
    if (!cnv) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (cnv_rise && sck) state_d = ST_CONV;
        ST_CONV:  if (load)            state_d = ST_ARMED;
        ST_ARMED: if (sck_fall)        state_d = ST_SHIFT;
        ST_SHIFT: state_d = ST_SHIFT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/dc_shifter.sv
// Result register: parallel load, serial shift toward the MSB with sdi entering at bit 0.
module dc_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         sin,
  output logic         msb,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (load)  word <= din;
    else if (shift) word <= {word[W-2:0], sin};
  end
  assign msb = word[W-1];
endmodule

// File: rtl/dchain_port.sv
module dchain_port
  import dc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_data
);
  localparam int unsigned PIN_N = 2;
  localparam int unsigned IDX_SCK = 0;
  localparam int unsigned IDX_CNV = 1;

  logic [PIN_N-1:0] pin_prev;
  logic             load_w;
  logic             shift_w;
  logic             msb_w;
  logic [WORD_W-1:0] word_q;
  dc_state_e        state_w;

  dc_pin_sampler #(.N(PIN_N)) u_sampler (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({cnv, sck}),
    .prev (pin_prev)
  );

  dc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv      (cnv),
    .cnv_prev (pin_prev[IDX_CNV]),
    .sck      (sck),
    .sck_prev (pin_prev[IDX_SCK]),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .load     (load_w),
    .shift    (shift_w),
    .state    (state_w)
  );

  dc_shifter #(.W(WORD_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_w),
    .din  (res_data),
    .shift(shift_w),
    .sin  (sdi),
    .msb  (msb_w),
    .word (word_q)
  );

  always_comb begin
    unique case (state_w)
      ST_ARMED: sdo = sdi;
      ST_SHIFT: sdo = msb_w;
      default:  sdo = 1'b0;
    endcase
  end
endmodule

// File: rtl/dchain_port_chk.sv
module dchain_port_chk
  import dc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic      clk,
  input logic      rst_n,
  input logic      cnv,
  input logic      sck,
  input logic      sdi,
  input logic      sdo,
  input logic      res_valid,
  input logic      res_ready,
  input dc_state_e state,
  input logic [W-1:0] word
);
  // R2: rising cnv with sck high starts a conversion
  assert_start_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $rose(cnv) && sck) |=> (state == ST_CONV));

  // R3: rising cnv with sck low leaves the port idle
  assert_low_sck_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $rose(cnv) && !sck) |=> (state == ST_IDLE && !res_ready));

  // R4: a taken word ends the ready window
  assert_take_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_ready && state == ST_ARMED));

  // R5: ready slot mirrors upstream; quiet while converting
  assert_ready_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) |-> (sdo == sdi));
  assert_conv_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |-> !sdo);

  // R6/R7: a falling edge in readback exposes the next stored bit
  assert_shift_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && cnv && $fell(sck)) |=> (sdo == $past(word[W-2])));

  // R8: cnv low forces the output low afterwards
  assert_cnv_low_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv |=> !sdo);

  // R9: sck falls do not disturb a conversion
  assert_conv_sck_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && cnv && $fell(sck) && !res_valid) |=> (state == ST_CONV));
endmodule

bind dchain_port dchain_port_chk #(.W(dc_pkg::WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnv      (cnv),
  .sck      (sck),
  .sdi      (sdi),
  .sdo      (sdo),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .state    (state_w),
  .word     (word_q)
);

// File: tb/dchain_port_tb_top.sv
module dchain_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0;
  logic sck = 1'b1;
  logic [2:0] vld = '0;            // index 0 far, 1 middle, 2 near
  logic [15:0] dat [3];
  logic [2:0] rdy;
  logic sdo_far, sdo_mid, sdo_near;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dchain_port far_i (.clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(cnv),
    .sdo(sdo_far), .res_valid(vld[0]), .res_ready(rdy[0]), .res_data(dat[0]));
  dchain_port mid_i (.clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_far),
    .sdo(sdo_mid), .res_valid(vld[1]), .res_ready(rdy[1]), .res_data(dat[1]));
  dchain_port dut_i (.clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_mid),
    .sdo(sdo_near), .res_valid(vld[2]), .res_ready(rdy[2]), .res_data(dat[2]));

  // {order, near word, middle word, far word}
  // order 0: far, mid, near; 1: near, mid, far; 2: mid, far, near; 3: all together
  localparam logic [49:0] VECS [4] = '{
    {2'd0, 16'hA5C3, 16'h1234, 16'hFFFE},
    {2'd1, 16'h0001, 16'h8000, 16'h7F80},
    {2'd2, 16'hFFFF, 16'h0000, 16'hC3A5},
    {2'd3, 16'h5AA5, 16'hDEAD, 16'h0F0F}
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_conv();
    sck = 1'b1;
    cnv = 1'b1;
    tick();
    tick();
  endtask

  task automatic end_cycle();
    cnv = 1'b0;
    tick();
    tick();
  endtask

  task automatic deliver(input logic [2:0] mask);
    vld = mask;
    tick();
    vld = '0;
  endtask

  task automatic fall_check(input string req, input logic exp);
    sck = 1'b0;
    tick();
    chk(req, {47'd0, sdo_near}, {47'd0, exp});
    sck = 1'b1;
    tick();
  endtask

  task automatic read_words(input logic [47:0] stream, input int nbits, input string req);
    for (int k = 1; k <= nbits; k++) fall_check(req, stream[48-k]);
  endtask

  initial begin
    dat[0] = '0; dat[1] = '0; dat[2] = '0;
    repeat (3) tick();
    // R1: reset state
    chk("R1 sdo in reset", {47'd0, sdo_near}, 48'd0);
    chk("R1 res_ready in reset", {45'd0, rdy}, 48'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 sdo after reset", {47'd0, sdo_near}, 48'd0);
    chk("R1 res_ready after reset", {45'd0, rdy}, 48'd0);

    // Table-driven full chain cycles
    for (int v = 0; v < 4; v++) begin
      logic [2:0] steps [3];
      int nsteps;
      dat[2] = VECS[v][47:32];
      dat[1] = VECS[v][31:16];
      dat[0] = VECS[v][15:0];
      case (VECS[v][49:48])
        2'd0: begin steps[0] = 3'b001; steps[1] = 3'b010; steps[2] = 3'b100; nsteps = 3; end
        2'd1: begin steps[0] = 3'b100; steps[1] = 3'b010; steps[2] = 3'b001; nsteps = 3; end
        2'd2: begin steps[0] = 3'b010; steps[1] = 3'b001; steps[2] = 3'b100; nsteps = 3; end
        default: begin steps[0] = 3'b111; steps[1] = 3'b000; steps[2] = 3'b000; nsteps = 1; end
      endcase
      start_conv();
      chk("R2 res_ready in conversion", {45'd0, rdy}, 48'h7);
      chk("R5 sdo low while converting", {47'd0, sdo_near}, 48'd0);
      for (int s = 0; s < nsteps; s++) begin
        deliver(steps[s]);
        chk("R4 res_ready after take", {45'd0, rdy}, {45'd0, rdy & ~steps[s]});
        if (s < nsteps - 1)
          chk("R5 no ready before whole chain", {47'd0, sdo_near}, 48'd0);
      end
      chk("R5 ready once whole chain holds words", {47'd0, sdo_near}, 48'd1);
      read_words(VECS[v][47:0], 48, "R6/R7 chain stream");
      fall_check("R7 tail from cnv", 1'b1);
      end_cycle();
      chk("R8 sdo low after cnv drop", {47'd0, sdo_near}, 48'd0);
    end

    // R3: rising cnv with sck low is ignored
    sck = 1'b0; tick();
    cnv = 1'b1; tick(); tick();
    chk("R3 res_ready stays low", {45'd0, rdy}, 48'd0);
    chk("R3 sdo stays low", {47'd0, sdo_near}, 48'd0);
    sck = 1'b1; tick();
    chk("R3 late sck rise does not start", {45'd0, rdy}, 48'd0);
    end_cycle();

    // R4: result offered while idle is held off, then taken at conversion start
    dat[2] = 16'hBEEF; dat[1] = 16'h4321; dat[0] = 16'h0880;
    vld = 3'b111; tick();
    chk("R4 no take while idle", {45'd0, rdy}, 48'd0);
    cnv = 1'b1; tick();
    chk("R4 ready in first conversion cycle", {45'd0, rdy}, 48'h7);
    tick();
    vld = '0;
    chk("R4 taken in first conversion cycle", {45'd0, rdy}, 48'd0);
    chk("R5 ready after early offer", {47'd0, sdo_near}, 48'd1);
    read_words({16'hBEEF, 16'h4321, 16'h0880}, 20, "R4 early word readback");
    // R8: cnv drop together with sck fall in readback
    sck = 1'b0; cnv = 1'b0; tick();
    chk("R8 sdo low on cnv drop with sck fall", {47'd0, sdo_near}, 48'd0);
    sck = 1'b1; tick();

    // R9: sck activity during conversion is ignored
    dat[2] = 16'h6C39; dat[1] = 16'h0101; dat[0] = 16'hF00F;
    start_conv();
    for (int p = 0; p < 3; p++) begin
      sck = 1'b0; tick(); sck = 1'b1; tick();
    end
    chk("R9 still converting after sck falls", {45'd0, rdy}, 48'h7);
    chk("R9 sdo low after sck falls", {47'd0, sdo_near}, 48'd0);
    deliver(3'b111);
    chk("R9 ready after deliveries", {47'd0, sdo_near}, 48'd1);
    read_words({16'h6C39, 16'h0101, 16'hF00F}, 48, "R9 readback after sck noise");
    end_cycle();

    // R8: cnv drop in the same cycle as a handshake on the near device
    dat[2] = 16'h1111;
    start_conv();
    deliver(3'b011);
    cnv = 1'b0; vld = 3'b100; tick();
    vld = '0; tick();
    chk("R8 aborted conversion idle", {45'd0, rdy}, 48'd0);
    dat[2] = 16'h2222; dat[1] = 16'h3333; dat[0] = 16'h4444;
    start_conv();
    chk("R8 restart ready on all", {45'd0, rdy}, 48'h7);
    deliver(3'b111);
    chk("R5 ready after restart", {47'd0, sdo_near}, 48'd1);
    read_words({16'h2222, 16'h3333, 16'h4444}, 16, "R8 new near word, not offered one");
    end_cycle();
    chk("R8 sdo low at end", {47'd0, sdo_near}, 48'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule